// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address into a physical address when a translation cache misses. A request carries a 32-bit virtual address, a write flag and a user-mode flag. The walker fetches one entry from the page directory, then one entry from the page table that the directory entry selects. It checks each entry, and only when it has to, writes the entry back with its accessed flag set (and, for the leaf on a write, its dirty flag). It then returns either a physical address for a 4 KB page or a classified fault.

Memory is reached through a single 32-bit port that uses a valid/ready handshake, and only one transaction is in flight at a time. The directory's page frame number comes from a base input, which is sampled when a request is accepted. A result or a fault is reported as a one-cycle pulse. The walker then accepts the next request.

Top module: `pw_walker`

## Requirements
- R1: A virtual address splits into directory index VA[31:22], table index VA[21:12] and offset VA[11:0]. The directory entry is read at {dir_base, 12'b0} + 4*VA[31:22]. The table entry is read at {directory entry[31:12], 12'b0} + 4*VA[21:12]. Every memory address is word aligned.
- R2: `dir_base` is sampled in the cycle a request is accepted. Changing it later alters only the walks accepted after the change.
- R3: A successful walk returns rsp_paddr = {leaf entry[31:12], VA[11:0]} with rsp_fault = 0.
- R4: If bit 0 (present) is 0 in either entry, the walk ends with rsp_fault = 1 and rsp_prot = 0. It makes no further memory access, and the leaf is not read when the directory entry is absent.
- R5: A user access (req_user = 1) that meets bit 2 = 0 in either entry faults with rsp_prot = 1. A write (req_write = 1) that meets bit 1 = 0 in either entry also faults with rsp_prot = 1. A supervisor read is not restricted by bits 1 and 2.
- R6: A fault echoes the request's virtual address on rsp_vaddr, its write flag on rsp_write and its user flag on rsp_user.
- R7: An entry that passes its checks and has bit 5 (accessed) clear is written back with bit 5 set and all other bits unchanged. A leaf reached by a write that has bit 6 (dirty) clear also gets bit 6 set in that single write.
- R8: No write-back happens when the needed flags are already set, and no write-back happens for an entry that faults.
- R9: The walker has at most one memory transaction outstanding. It holds mem_valid, mem_addr, mem_write and mem_wdata stable until mem_ready. req_ready is high only while the walker is idle, and no memory access occurs while it is idle.
- R10: After reset, req_ready is 1 and mem_valid and rsp_valid are 0. Each accepted request yields exactly one rsp_valid pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle, request accepted on this edge |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| dir_base | input | 20 | Page frame number of the page directory |
| mem_valid | output | 1 | Memory transaction requested |
| mem_ready | input | 1 | Memory accepts/completes the transaction this cycle |
| mem_write | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry value for write-back |
| mem_rdata | input | 32 | Entry value, valid in the handshake cycle of a read |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Walk ended in a page fault |
| rsp_prot | output | 1 | Fault cause: 1 = protection, 0 = not present |
| rsp_paddr | output | 32 | Physical address (zero on a fault) |
| rsp_vaddr | output | 32 | Virtual address of the finished walk |
| rsp_write | output | 1 | Access type of the finished walk |
| rsp_user | output | 1 | Privilege of the finished walk |

## Verification
The assertions assume that the memory side returns read data in the same cycle it raises mem_ready. They do not assume that mem_ready follows any pattern, and the bench deliberately stalls it on a repeating cycle. They also assume that requests are offered only while req_ready is high. The bench drives req_valid for exactly one idle cycle per walk and waits for the response pulse before it offers another request. The page tables live in a sparse memory model in the bench. Vectors are ordered so that later walks meet entries whose flags earlier walks have already set.

// File: rtl/pw_pkg.sv
package pw_pkg;
   // Entry flag positions (behaviour depends on these)
   localparam int unsigned PB_PRESENT  = 0;
   localparam int unsigned PB_WRITABLE = 1;
   localparam int unsigned PB_USER     = 2;
   localparam int unsigned PB_ACCESSED = 5;
   localparam int unsigned PB_DIRTY    = 6;

   typedef enum logic [3:0] {
      S_IDLE,
      S_DIR_RD,
      S_DIR_CHK,
      S_DIR_WB,
      S_TBL_RD,
      S_TBL_CHK,
      S_TBL_WB,
      S_DONE,
      S_FAULT
   } walk_st_e;
endpackage

// File: rtl/pw_entry_chk.sv
module pw_entry_chk #(
   parameter int unsigned ENT_W = 32,
   parameter bit          LEAF  = 1'b0
) (
   input  logic [ENT_W-1:0] entry,
   input  logic             acc_wr,
   input  logic             acc_us,
   output logic             not_present,
   output logic             prot_viol,
   output logic             need_wb,
   output logic [ENT_W-1:0] wb_data
);
   import pw_pkg::*;

   logic [ENT_W-1:0] set_mask;

   always_comb begin
      not_present = !entry[PB_PRESENT];
      prot_viol   = (acc_us && !entry[PB_USER]) || (acc_wr && !entry[PB_WRITABLE]);
   end

   generate
      if (LEAF) begin : g_leaf
         assign set_mask = (ENT_W'(1) << PB_ACCESSED)
                         | (acc_wr ? (ENT_W'(1) << PB_DIRTY) : '0);
      end else begin : g_dir
         assign set_mask = ENT_W'(1) << PB_ACCESSED;
      end
   endgenerate

   assign need_wb = (entry & set_mask) != set_mask;
   assign wb_data = entry | set_mask;
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned OFF_W    = 12,
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned ENT_LOG2 = 2,
   localparam int unsigned PG_W    = ADDR_W - OFF_W,
   localparam int unsigned PAD_W   = OFF_W - IDX_W - ENT_LOG2
) (
   input  logic [PG_W-1:0]   frame,
   input  logic [IDX_W-1:0]  index,
   output logic [ADDR_W-1:0] addr
);
   generate
      if (PAD_W > 0) begin : g_pad
         assign addr = {frame, {PAD_W{1'b0}}, index, {ENT_LOG2{1'b0}}};
      end else begin : g_nopad
         assign addr = {frame, index, {ENT_LOG2{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/pw_walker.sv
module pw_walker #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned OFF_W    = 12,
   parameter int unsigned ENT_LOG2 = 2,
   localparam int unsigned PG_W    = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic              req_write,
   input  logic              req_user,
   input  logic [PG_W-1:0]   dir_base,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic              rsp_prot,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic [ADDR_W-1:0] rsp_vaddr,
   output logic              rsp_write,
   output logic              rsp_user
);
   import pw_pkg::*;

   if (ADDR_W != 2 * IDX_W + OFF_W) begin : g_bad_split
      $error("pw_walker: ADDR_W must equal two indexes plus the offset");
   end
   if ((8 << ENT_LOG2) != ADDR_W) begin : g_bad_entry
      $error("pw_walker: entry size must match ADDR_W");
   end
   if (OFF_W < IDX_W + ENT_LOG2) begin : g_bad_table
      $error("pw_walker: a table must fit in one page");
   end

   walk_st_e          st_q;
   logic [ADDR_W-1:0] va_q;
   logic              wr_q, us_q, prot_q;
   logic [PG_W-1:0]   dbase_q, tbase_q, pfn_q;
   logic [ADDR_W-1:0] ent_q, wb_q;
   logic [ADDR_W-1:0] dir_addr, tbl_addr;

   logic              d_np, d_pv, d_need;
   logic [ADDR_W-1:0] d_wb;
   logic              l_np, l_pv, l_need;
   logic [ADDR_W-1:0] l_wb;

   pw_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LOG2(ENT_LOG2)) u_dir_addr (
      .frame (dbase_q),
      .index (va_q[ADDR_W-1 -: IDX_W]),
      .addr  (dir_addr)
   );

   pw_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LOG2(ENT_LOG2)) u_tbl_addr (
      .frame (tbase_q),
      .index (va_q[OFF_W +: IDX_W]),
      .addr  (tbl_addr)
   );

   pw_entry_chk #(.ENT_W(ADDR_W), .LEAF(1'b0)) u_dir_chk (
      .entry       (ent_q),
      .acc_wr      (wr_q),
      .acc_us      (us_q),
      .not_present (d_np),
      .prot_viol   (d_pv),
      .need_wb     (d_need),
      .wb_data     (d_wb)
   );

   pw_entry_chk #(.ENT_W(ADDR_W), .LEAF(1'b1)) u_leaf_chk (
      .entry       (ent_q),
      .acc_wr      (wr_q),
      .acc_us      (us_q),
      .not_present (l_np),
      .prot_viol   (l_pv),
      .need_wb     (l_need),
      .wb_data     (l_wb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         va_q    <= '0;
         wr_q    <= 1'b0;
         us_q    <= 1'b0;
         prot_q  <= 1'b0;
         dbase_q <= '0;
         tbase_q <= '0;
         pfn_q   <= '0;
         ent_q   <= '0;
         wb_q    <= '0;
      end else begin
         unique case (st_q)
            S_IDLE: if (req_valid) begin
               va_q    <= req_vaddr;
               wr_q    <= req_write;
               us_q    <= req_user;
               dbase_q <= dir_base;
               prot_q  <= 1'b0;
               st_q    <= S_DIR_RD;
            end
            S_DIR_RD: if (mem_ready) begin
               ent_q <= mem_rdata;
               st_q  <= S_DIR_CHK;
            end
            S_DIR_CHK: begin
               tbase_q <= ent_q[ADDR_W-1:OFF_W];
               wb_q    <= d_wb;
               if (d_np) begin
                  st_q <= S_FAULT;
               end else if (d_pv) begin
                  prot_q <= 1'b1;
                  st_q   <= S_FAULT;
               end else begin
                  st_q <= d_need ? S_DIR_WB : S_TBL_RD;
               end
            end
            S_DIR_WB: if (mem_ready) st_q <= S_TBL_RD;
            S_TBL_RD: if (mem_ready) begin
               ent_q <= mem_rdata;
               st_q  <= S_TBL_CHK;
            end
            S_TBL_CHK: begin
               pfn_q <= ent_q[ADDR_W-1:OFF_W];
               wb_q  <= l_wb;
               if (l_np) begin
                  st_q <= S_FAULT;
               end else if (l_pv) begin
                  prot_q <= 1'b1;
                  st_q   <= S_FAULT;
               end else begin
                  st_q <= l_need ? S_TBL_WB : S_DONE;
               end
            end
            S_TBL_WB: if (mem_ready) st_q <= S_DONE;
            S_DONE:   st_q <= S_IDLE;
            S_FAULT:  st_q <= S_IDLE;
            default:  st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready = (st_q == S_IDLE);
      mem_valid = (st_q == S_DIR_RD) || (st_q == S_DIR_WB)
               || (st_q == S_TBL_RD) || (st_q == S_TBL_WB);
      mem_write = (st_q == S_DIR_WB) || (st_q == S_TBL_WB);
      mem_addr  = ((st_q == S_TBL_RD) || (st_q == S_TBL_WB)) ? tbl_addr : dir_addr;
      mem_wdata = wb_q;
      rsp_valid = (st_q == S_DONE) || (st_q == S_FAULT);
      rsp_fault = (st_q == S_FAULT);
      rsp_prot  = (st_q == S_FAULT) && prot_q;
      rsp_paddr = (st_q == S_DONE) ? {pfn_q, va_q[OFF_W-1:0]} : '0;
      rsp_vaddr = va_q;
      rsp_write = wr_q;
      rsp_user  = us_q;
   end
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic              mem_write,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] mem_wdata,
   input logic              rsp_valid,
   input logic              rsp_fault,
   input logic              rsp_prot,
   input logic [ADDR_W-1:0] rsp_paddr,
   input logic [ADDR_W-1:0] rsp_vaddr
);
   a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                  && $stable(mem_write) && $stable(mem_wdata));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_valid);

   a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> mem_addr[1:0] == 2'b00);

   a_r7_wb_marks_accessed: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_write |-> mem_wdata[5] && mem_wdata[0]);

   a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]);

   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r10_busy_on_result: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   a_r5_prot_is_fault: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_prot |-> rsp_fault);
endmodule

bind pw_walker pw_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_pw_walker_chk (.*);

// File: tb/pw_walker_bench.sv
module pw_walker_bench;
   typedef struct packed {
      logic [31:0] va;
      logic        wr;
      logic        us;
      logic        flt;
      logic        prot;
      logic [31:0] pa;
      logic [3:0]  nw;
   } vec_t;

   // Ordered: later walks see flags set by earlier ones
   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0123, 1'b0, 1'b1, 1'b0, 1'b0, 32'hABCD_E123, 4'd2},
      '{32'h0000_0456, 1'b1, 1'b1, 1'b0, 1'b0, 32'hABCD_E456, 4'd1},
      '{32'h0000_1FFF, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1234_5FFF, 4'd1},
      '{32'h0000_1000, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 4'd0},
      '{32'h0000_2010, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 4'd0},
      '{32'h0000_3ABC, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 4'd0},
      '{32'h0000_3ABC, 1'b1, 1'b0, 1'b0, 1'b0, 32'h5555_5ABC, 4'd1},
      '{32'h0040_0000, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 4'd0},
      '{32'h0040_0000, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_0000, 4'd0},
      '{32'h0040_0FF0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h9999_9FF0, 4'd2},
      '{32'h0080_0000, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 4'd0},
      '{32'h00C0_4008, 1'b1, 1'b1, 1'b0, 1'b0, 32'h7777_7008, 4'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic [19:0] dir_base = 20'h00001;
   logic        mem_valid, mem_write;
   logic        mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        rsp_valid, rsp_fault, rsp_prot, rsp_write, rsp_user;
   logic [31:0] rsp_paddr, rsp_vaddr;

   logic [31:0] mem [logic [31:0]];
   int          wcnt = 0;
   int          reads_after = 0;
   logic [1:0]  rcyc = '0;
   int          n_chk = 0;
   int          n_bad = 0;

   always #5 clk = ~clk;

   pw_walker u_pw_walker (.*);

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   assign mem_ready = (rcyc != 2'b00);
   assign mem_rdata = rd(mem_addr);

   always_ff @(posedge clk) begin
      rcyc <= rcyc + 2'd1;
      if (mem_valid && mem_ready) begin
         if (mem_write) begin
            mem[mem_addr] = mem_wdata;
            wcnt <= wcnt + 1;
         end
         reads_after <= reads_after + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic walk(input logic [31:0] va, input logic wr, input logic us, output bit got);
      int t;
      got = 1'b0;
      t = 0;
      while (!req_ready && t < 300) begin @(negedge clk); t++; end
      req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!rsp_valid && t < 300) begin @(negedge clk); t++; end
      got = rsp_valid;
      if (!got) chk(1'b0, "watchdog no response", 32'h0, 32'h1);
   endtask

   initial begin
      bit got;
      int w0;
      mem[32'h0000_1000] = 32'h0000_2007;
      mem[32'h0000_1004] = 32'h0000_3001;
      mem[32'h0000_1008] = 32'h0000_0000;
      mem[32'h0000_100C] = 32'h0000_2027;
      mem[32'h0000_2000] = 32'hABCD_E007;
      mem[32'h0000_2004] = 32'h1234_5005;
      mem[32'h0000_2008] = 32'h0000_0006;
      mem[32'h0000_200C] = 32'h5555_5003;
      mem[32'h0000_2010] = 32'h7777_7067;
      mem[32'h0000_3000] = 32'h9999_9003;

      repeat (3) @(negedge clk);
      // R10 reset state
      chk(req_ready == 1'b1, "R10 reset req_ready", 32'(req_ready), 32'h1);
      chk(mem_valid == 1'b0, "R10 reset mem_valid", 32'(mem_valid), 32'h0);
      chk(rsp_valid == 1'b0, "R10 reset rsp_valid", 32'(rsp_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         w0 = wcnt;
         walk(VECS[i].va, VECS[i].wr, VECS[i].us, got);
         if (got) begin
            chk(rsp_fault == VECS[i].flt, $sformatf("R4 R5 v%0d fault", i), 32'(rsp_fault), 32'(VECS[i].flt));
            if (VECS[i].flt) begin
               chk(rsp_prot == VECS[i].prot, $sformatf("R5 v%0d cause", i), 32'(rsp_prot), 32'(VECS[i].prot));
               chk(rsp_vaddr == VECS[i].va, $sformatf("R6 v%0d vaddr", i), rsp_vaddr, VECS[i].va);
               chk(rsp_write == VECS[i].wr && rsp_user == VECS[i].us, $sformatf("R6 v%0d wr/us", i),
                   {30'h0, rsp_write, rsp_user}, {30'h0, VECS[i].wr, VECS[i].us});
            end else begin
               chk(rsp_paddr == VECS[i].pa, $sformatf("R1 R3 v%0d paddr", i), rsp_paddr, VECS[i].pa);
            end
            @(negedge clk);
            chk(!rsp_valid, $sformatf("R10 v%0d pulse ends", i), 32'(rsp_valid), 32'h0);
         end
         chk(wcnt - w0 == int'(VECS[i].nw), $sformatf("R7 R8 v%0d writebacks", i), 32'(wcnt - w0), 32'(VECS[i].nw));
      end

      // R7: updated flags merged into the stored entries
      chk(rd(32'h0000_1000) == 32'h0000_2027, "R7 dir0 accessed", rd(32'h0000_1000), 32'h0000_2027);
      chk(rd(32'h0000_2000) == 32'hABCD_E067, "R7 leaf0 dirty", rd(32'h0000_2000), 32'hABCD_E067);
      chk(rd(32'h0000_2004) == 32'h1234_5025, "R7 leaf1 accessed", rd(32'h0000_2004), 32'h1234_5025);
      chk(rd(32'h0000_200C) == 32'h5555_5063, "R7 leaf3 dirty", rd(32'h0000_200C), 32'h5555_5063);
      chk(rd(32'h0000_1004) == 32'h0000_3021, "R7 dir1 accessed", rd(32'h0000_1004), 32'h0000_3021);
      chk(rd(32'h0000_3000) == 32'h9999_9023, "R7 leaf in table 3", rd(32'h0000_3000), 32'h9999_9023);
      // R8: faulting entries untouched
      chk(rd(32'h0000_2008) == 32'h0000_0006, "R8 absent leaf kept", rd(32'h0000_2008), 32'h0000_0006);
      chk(rd(32'h0000_1008) == 32'h0000_0000, "R8 absent dir kept", rd(32'h0000_1008), 32'h0000_0000);

      // R4: absent directory entry stops after one read
      w0 = reads_after;
      walk(32'h0080_0123, 1'b0, 1'b0, got);
      chk(reads_after - w0 == 1, "R4 one access on absent dir", 32'(reads_after - w0), 32'h1);

      // R2: base sampled at acceptance; new base points to an empty directory
      dir_base = 20'h00005;
      walk(32'h0000_0123, 1'b0, 1'b0, got);
      chk(got && rsp_fault && !rsp_prot, "R2 new base used", {30'h0, rsp_fault, rsp_prot}, 32'h2);
      dir_base = 20'h00001;
      walk(32'h0000_0123, 1'b0, 1'b0, got);
      chk(got && !rsp_fault && rsp_paddr == 32'hABCD_E123, "R2 base restored", rsp_paddr, 32'hABCD_E123);

      // R9: idle again after the walk, memory quiet
      @(negedge clk);
      chk(req_ready && !mem_valid, "R9 idle quiet", {30'h0, req_ready, mem_valid}, 32'h2);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule